// File: doc/BRIEF.md
# Serial Audio Link Input-Frame Receiver

This block sits on the controller side of a serial audio codec link and takes apart the frame the codec sends back. It shifts in the serial data line on every bit strobe and finds the start of each frame from the rising edge of the frame marker. Each frame is 256 bits long: a 16-bit tag word followed by twelve 20-bit slots. The tag word is decoded into a link-ready flag and per-slot valid flags.

The status slots carry the echoed register index and the register read data. They are presented on plain status pins. The eight capture slots carry 18-bit PCM samples, and these leave the block as a valid/ready stream. Each beat is one sample, rounded to the output width and tagged with its channel number.

All results of a frame take effect together, once the last bit of that frame has been received. Back-pressure on the stream never stalls the link. When a frame completes, the samples of the previous frame that have not yet been sent are dropped. The one exception is a beat already on offer, which stays on the port until it is accepted. A consumer must therefore accept the eight beats of a frame within one frame time.

Top module: `audlink_rx`

## Requirements
- R1: After reset, `link_ready`, `stat_idx_vld`, `stat_data_vld` and `pcm_valid` are all 0.
- R2: Line values are sampled only in cycles with `bit_en` high. A frame begins at the strobe where `sync_in` is 1 and was 0 at the previous strobe; that strobe carries the tag's bit 15. The tag (16 bits) is followed by slots 1 to 12 (20 bits each), and every field is sent MSB first.
- R3: `link_ready` equals tag bit 15 of the most recently completed frame. It changes only when a frame completes.
- R4: While tag bit 15 of the completed frame is 0, `stat_idx_vld` and `stat_data_vld` are 0 and no sample of that frame is emitted.
- R5: `stat_idx` holds slot 1 bits 18..12 of the last frame. `stat_idx_vld` is 1 only when that frame had tag bits 15 and 14 set.
- R6: `stat_data` holds slot 2 bits 19..4 of the last frame. `stat_data_vld` is 1 only when that frame had tag bits 15 and 13 set.
- R7: For slot n in 3..10, the sample is slot bits 19..2 (signed). It is emitted on channel `pcm_ch` = n-3 only if tag bit 15-n is set. The valid samples of a frame leave in ascending channel order.
- R8: `pcm_data` is the sample plus half an output LSB, keeping the upper OUT_W bits. A positive overflow saturates to the largest positive value instead of wrapping.
- R9: While `pcm_valid` is 1 and `pcm_ready` is 0, `pcm_valid`, `pcm_ch` and `pcm_data` hold their values. Each cycle with both high transfers exactly one beat.
- R10: When a frame completes, unsent samples of the previous frame are discarded. A beat on offer is still delivered, and it is followed by the new frame's samples.
- R11: A frame that is cut short by a new rising frame marker changes no output. The frame restarted by that marker is received in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe at each falling edge of the link bit clock |
| sync_in | input | 1 | Frame marker from the link |
| sdata_in | input | 1 | Serial input data from the codec |
| link_ready | output | 1 | Codec-ready flag of the last frame |
| stat_idx | output | 7 | Echoed register index |
| stat_idx_vld | output | 1 | `stat_idx` is valid |
| stat_data | output | 16 | Register read data |
| stat_data_vld | output | 1 | `stat_data` is valid |
| pcm_valid | output | 1 | Sample beat on offer |
| pcm_ready | input | 1 | Consumer accepts the beat |
| pcm_ch | output | 3 | Channel of the beat (slot number minus 3) |
| pcm_data | output | OUT_W | Rounded signed sample |

## Verification
Several properties are checked on every cycle:
- the held beat stays stable under back-pressure;
- the status and sample flags stay gated while the link is not ready;
- slot words never arrive on adjacent cycles or beyond the last slot index.

Other behaviours only the directed scenarios can show:
- bit ordering and field positions;
- the rounding and saturation values;
- ascending emission order;
- dropping of stale samples on a new frame;
- the absence of any commit from a cut-short frame.

// File: rtl/audlink_pkg.sv
package audlink_pkg;
  localparam int TAG_BITS      = 16;
  localparam int SLOT_BITS     = 20;
  localparam int DATA_SLOTS    = 12;
  localparam int SAMPLE_BITS   = 18;
  localparam int PCM_CHANNELS  = 8;
  localparam int PCM_SLOT_BASE = 3;
  localparam int REG_IDX_BITS  = 7;
  localparam int REG_DAT_BITS  = 16;
endpackage

// File: rtl/audlink_deser.sv
module audlink_deser #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  localparam int IDX_W  = $clog2(N_SLOTS + 1),
  localparam int POS_W  = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sync_in,
  input  logic              sdata_in,
  output logic              word_vld,
  output logic [SLOT_W-1:0] word,
  output logic [IDX_W-1:0]  word_idx
);
  logic              sync_q;
  logic              active;
  logic [IDX_W-1:0]  slot_idx;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-2:0] shreg;
  logic              sync_rise;
  logic              last_bit;

  assign sync_rise = sync_in & ~sync_q;
  assign last_bit  = (slot_idx == '0) ? (pos == POS_W'(TAG_W - 1))
                                      : (pos == POS_W'(SLOT_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active   <= 1'b0;
      slot_idx <= '0;
      pos      <= '0;
      shreg    <= '0;
      word_vld <= 1'b0;
      word     <= '0;
      word_idx <= '0;
    end else begin
      word_vld <= 1'b0;
      if (bit_en) begin
        sync_q <= sync_in;
        if (sync_rise) begin
          active   <= 1'b1;
          slot_idx <= '0;
          pos      <= POS_W'(1);
          shreg    <= {{(SLOT_W-2){1'b0}}, sdata_in};
        end else if (active) begin
          shreg <= {shreg[SLOT_W-3:0], sdata_in};
          if (last_bit) begin
            word_vld <= 1'b1;
            word     <= {shreg, sdata_in};
            word_idx <= slot_idx;
            pos      <= '0;
            if (slot_idx == IDX_W'(N_SLOTS)) active <= 1'b0;
            else                             slot_idx <= slot_idx + 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end

  AST_WORD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R2
  AST_WORD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (word_idx <= IDX_W'(N_SLOTS))); // R2
endmodule

// File: rtl/audlink_capture.sv
module audlink_capture #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int N_SLOTS   = 12,
  parameter int SMP_W     = 18,
  parameter int N_CH      = 8,
  parameter int CH_BASE   = 3,
  parameter int RIDX_W    = 7,
  parameter int RDAT_W    = 16,
  localparam int IDX_W    = $clog2(N_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_vld,
  input  logic [SLOT_W-1:0]          word,
  input  logic [IDX_W-1:0]           word_idx,
  output logic                       link_rdy,
  output logic [RIDX_W-1:0]          ridx,
  output logic                       ridx_vld,
  output logic [RDAT_W-1:0]          rdat,
  output logic                       rdat_vld,
  output logic                       frame_commit,
  output logic [N_CH-1:0]            ch_mask,
  output logic [N_CH-1:0][SMP_W-1:0] ch_raw
);
  logic [TAG_W-1:0]           stg_tag;
  logic [RIDX_W-1:0]          stg_ridx;
  logic [RDAT_W-1:0]          stg_rdat;
  logic [N_CH-1:0][SMP_W-1:0] stg_raw;
  logic                       stg_rdy;

  assign stg_rdy = stg_tag[TAG_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_tag      <= '0;
      stg_ridx     <= '0;
      stg_rdat     <= '0;
      stg_raw      <= '0;
      link_rdy     <= 1'b0;
      ridx         <= '0;
      ridx_vld     <= 1'b0;
      rdat         <= '0;
      rdat_vld     <= 1'b0;
      frame_commit <= 1'b0;
      ch_mask      <= '0;
      ch_raw       <= '0;
    end else begin
      frame_commit <= 1'b0;
      if (word_vld) begin
        if (word_idx == '0)          stg_tag  <= word[TAG_W-1:0];
        if (word_idx == IDX_W'(1))   stg_ridx <= word[SLOT_W-2 -: RIDX_W];
        if (word_idx == IDX_W'(2))   stg_rdat <= word[SLOT_W-1 -: RDAT_W];
        for (int c = 0; c < N_CH; c++) begin
          if (word_idx == IDX_W'(CH_BASE + c)) stg_raw[c] <= word[SLOT_W-1 -: SMP_W];
        end
        if (word_idx == IDX_W'(N_SLOTS)) begin
          frame_commit <= 1'b1;
          link_rdy     <= stg_rdy;
          ridx         <= stg_ridx;
          ridx_vld     <= stg_rdy & stg_tag[TAG_W-2];
          rdat         <= stg_rdat;
          rdat_vld     <= stg_rdy & stg_tag[TAG_W-3];
          ch_raw       <= stg_raw;
          for (int c = 0; c < N_CH; c++) begin
            ch_mask[c] <= stg_rdy & stg_tag[TAG_W-1-CH_BASE-c];
          end
        end
      end
    end
  end

  AST_NOT_READY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rdy |-> (!ridx_vld && !rdat_vld && (ch_mask == '0))); // R4
endmodule

// File: rtl/audlink_round.sv
module audlink_round #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W >= IN_W) begin : g_pass
      assign dout = OUT_W'($signed(din));
    end else begin : g_round
      localparam int DROP = IN_W - OUT_W;
      logic [IN_W-1:0] sum;
      logic            ovf;
      assign sum  = din + IN_W'(1 << (DROP - 1));
      assign ovf  = ~din[IN_W-1] & sum[IN_W-1];
      assign dout = ovf ? {1'b0, {(OUT_W-1){1'b1}}} : sum[IN_W-1 -: OUT_W];
    end
  endgenerate
endmodule

// File: rtl/audlink_pcm_stream.sv
module audlink_pcm_stream #(
  parameter int N_CH  = 8,
  parameter int OUT_W = 16,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [N_CH-1:0]            mask,
  input  logic [N_CH-1:0][OUT_W-1:0] smp,
  output logic                       o_vld,
  input  logic                       o_rdy,
  output logic [CH_W-1:0]            o_ch,
  output logic [OUT_W-1:0]           o_data
);
  logic [N_CH-1:0] pend;
  logic [CH_W-1:0] sel;
  logic            take;

  always_comb begin
    sel = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (pend[c]) sel = CH_W'(c);
    end
  end

  assign take = (~o_vld | o_rdy) & (|pend) & ~commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      o_vld  <= 1'b0;
      o_ch   <= '0;
      o_data <= '0;
    end else begin
      if (commit)    pend      <= mask;
      else if (take) pend[sel] <= 1'b0;
      if (take) begin
        o_vld  <= 1'b1;
        o_ch   <= sel;
        o_data <= smp[sel];
      end else if (o_rdy) begin
        o_vld  <= 1'b0;
      end
    end
  end

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && !o_rdy) |=> (o_vld && $stable(o_ch) && $stable(o_data))); // R9
endmodule

// File: rtl/audlink_rx.sv
module audlink_rx
  import audlink_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    sync_in,
  input  logic                    sdata_in,
  output logic                    link_ready,
  output logic [REG_IDX_BITS-1:0] stat_idx,
  output logic                    stat_idx_vld,
  output logic [REG_DAT_BITS-1:0] stat_data,
  output logic                    stat_data_vld,
  output logic                    pcm_valid,
  input  logic                    pcm_ready,
  output logic [$clog2(PCM_CHANNELS)-1:0] pcm_ch,
  output logic [OUT_W-1:0]        pcm_data
);
  localparam int IDX_W = $clog2(DATA_SLOTS + 1);

  logic                                    word_vld;
  logic [SLOT_BITS-1:0]                    word;
  logic [IDX_W-1:0]                        word_idx;
  logic                                    commit;
  logic [PCM_CHANNELS-1:0]                 ch_mask;
  logic [PCM_CHANNELS-1:0][SAMPLE_BITS-1:0] ch_raw;
  logic [PCM_CHANNELS-1:0][OUT_W-1:0]      ch_round;

  audlink_deser #(
    .TAG_W(TAG_BITS), .SLOT_W(SLOT_BITS), .N_SLOTS(DATA_SLOTS)
  ) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_in(sync_in),
    .sdata_in(sdata_in), .word_vld(word_vld), .word(word), .word_idx(word_idx)
  );

  audlink_capture #(
    .TAG_W(TAG_BITS), .SLOT_W(SLOT_BITS), .N_SLOTS(DATA_SLOTS),
    .SMP_W(SAMPLE_BITS), .N_CH(PCM_CHANNELS), .CH_BASE(PCM_SLOT_BASE),
    .RIDX_W(REG_IDX_BITS), .RDAT_W(REG_DAT_BITS)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .word_idx(word_idx), .link_rdy(link_ready), .ridx(stat_idx),
    .ridx_vld(stat_idx_vld), .rdat(stat_data), .rdat_vld(stat_data_vld),
    .frame_commit(commit), .ch_mask(ch_mask), .ch_raw(ch_raw)
  );

  generate
    for (genvar c = 0; c < PCM_CHANNELS; c++) begin : g_rnd
      audlink_round #(.IN_W(SAMPLE_BITS), .OUT_W(OUT_W)) u_round (
        .din(ch_raw[c]), .dout(ch_round[c])
      );
    end
  endgenerate

  audlink_pcm_stream #(.N_CH(PCM_CHANNELS), .OUT_W(OUT_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .commit(commit), .mask(ch_mask),
    .smp(ch_round), .o_vld(pcm_valid), .o_rdy(pcm_ready),
    .o_ch(pcm_ch), .o_data(pcm_data)
  );
endmodule

// File: tb/audlink_rx_bench.sv
`timescale 1ns/1ps
module audlink_rx_bench;
  localparam int OUT_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, sync_in = 1'b0, sdata_in = 1'b0, pcm_ready = 1'b0;
  logic link_ready, stat_idx_vld, stat_data_vld, pcm_valid;
  logic [6:0] stat_idx;
  logic [15:0] stat_data;
  logic [2:0] pcm_ch;
  logic [OUT_W-1:0] pcm_data;

  audlink_rx #(.OUT_W(OUT_W)) u_audlink_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_in(sync_in), .sdata_in(sdata_in),
    .link_ready(link_ready), .stat_idx(stat_idx), .stat_idx_vld(stat_idx_vld),
    .stat_data(stat_data), .stat_data_vld(stat_data_vld), .pcm_valid(pcm_valid),
    .pcm_ready(pcm_ready), .pcm_ch(pcm_ch), .pcm_data(pcm_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] f_tag;
  logic [19:0] f_slot [1:12];
  logic [17:0] smp [0:7];
  int got_n;
  logic [2:0] got_ch [0:15];
  logic [OUT_W-1:0] got_d [0:15];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_round(input logic [17:0] raw);
    int v, r, top;
    v = $signed(raw);
    r = (v + (1 << (17 - OUT_W))) >>> (18 - OUT_W);
    top = (1 << (OUT_W - 1)) - 1;
    if (r > top) r = top;
    return r & ((1 << OUT_W) - 1);
  endfunction

  function automatic logic [15:0] mk_tag(input logic rdy, input logic v1, input logic v2, input logic [7:0] chm);
    logic [15:0] t;
    t = '0;
    t[15] = rdy; t[14] = v1; t[13] = v2;
    for (int c = 0; c < 8; c++) t[12-c] = chm[c];
    return t;
  endfunction

  task automatic build(input logic [15:0] tag, input logic [6:0] ri, input logic [15:0] rd);
    f_tag = tag;
    f_slot[1] = {1'b0, ri, 12'h000};
    f_slot[2] = {rd, 4'h0};
    for (int c = 0; c < 8; c++) f_slot[3+c] = {smp[c], 2'b00};
    f_slot[11] = 20'hA5A5A;
    f_slot[12] = 20'h5A5A5;
  endtask

  // one strobe per bit; line values are scrambled between strobes (R2)
  task automatic send_bits(input int nbits);
    for (int b = 0; b < nbits; b++) begin
      logic d;
      if (b < 16) d = f_tag[15-b];
      else d = f_slot[(b-16)/20 + 1][19 - ((b-16)%20)];
      @(posedge clk); #1;
      sync_in = (b < 16); sdata_in = d; bit_en = 1'b1;
      @(posedge clk); #1;
      bit_en = 1'b0; sdata_in = ~d; sync_in = ~sync_in;
    end
    @(posedge clk); #1;
    sync_in = 1'b0; sdata_in = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic drain(input int cycles);
    got_n = 0;
    @(posedge clk); #1; pcm_ready = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      if (pcm_valid && pcm_ready && got_n < 16) begin
        got_ch[got_n] = pcm_ch; got_d[got_n] = pcm_data; got_n++;
      end
    end
    @(posedge clk); #1; pcm_ready = 1'b0;
  endtask

  task automatic check_beats(input logic [7:0] chm, input string req);
    int k = 0;
    for (int c = 0; c < 8; c++) begin
      if (chm[c]) begin
        if (k < got_n) begin
          chk(got_ch[k] == 3'(c), req, "beat channel", got_ch[k], c);
          chk(got_d[k] == OUT_W'(exp_round(smp[c])), "R8", "rounded sample", got_d[k], exp_round(smp[c]));
        end
        k++;
      end
    end
    chk(got_n == k, req, "beat count", got_n, k);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(link_ready == 1'b0, "R1", "link_ready", link_ready, 0);
    chk(stat_idx_vld == 1'b0 && stat_data_vld == 1'b0, "R1", "status valid", stat_idx_vld + stat_data_vld, 0);
    chk(pcm_valid == 1'b0, "R1", "pcm_valid", pcm_valid, 0);
  endtask

  task automatic t_not_ready;
    for (int c = 0; c < 8; c++) smp[c] = 18'(c * 1000 + 7);
    build(mk_tag(1'b0, 1'b1, 1'b1, 8'hFF), 7'h33, 16'h1234);
    send_bits(256);
    @(negedge clk);
    chk(link_ready == 1'b0, "R3", "link_ready low frame", link_ready, 0);
    chk(stat_idx_vld == 1'b0 && stat_data_vld == 1'b0, "R4", "status gated", stat_idx_vld + stat_data_vld, 0);
    drain(40);
    chk(got_n == 0, "R4", "no beats while not ready", got_n, 0);
  endtask

  task automatic t_full;
    smp[0] = 18'h1FFFF; smp[1] = 18'h00006; smp[2] = 18'h00005; smp[3] = 18'h3FFFD;
    smp[4] = 18'h3FFFA; smp[5] = 18'h20000; smp[6] = 18'h1FFFD; smp[7] = 18'h12345;
    build(mk_tag(1'b1, 1'b1, 1'b1, 8'hFF), 7'h5A, 16'hBEEF);
    send_bits(256);
    @(negedge clk);
    chk(link_ready == 1'b1, "R3", "link_ready", link_ready, 1);
    chk(stat_idx == 7'h5A && stat_idx_vld, "R5", "status index (R2 order)", stat_idx, 'h5A);
    chk(stat_data == 16'hBEEF && stat_data_vld, "R6", "read data (R2 order)", stat_data, 'hBEEF);
    drain(40);
    check_beats(8'hFF, "R7");
    chk(got_d[0] == 16'h7FFF, "R8", "saturation", got_d[0], 'h7FFF);
  endtask

  task automatic t_partial;
    for (int c = 0; c < 8; c++) smp[c] = 18'(c * 4099 + 3);
    build(mk_tag(1'b1, 1'b0, 1'b1, 8'b0100_0010), 7'h11, 16'h0F0F);
    send_bits(256);
    @(negedge clk);
    chk(stat_idx_vld == 1'b0, "R5", "index valid off", stat_idx_vld, 0);
    chk(stat_data_vld == 1'b1 && stat_data == 16'h0F0F, "R6", "read data", stat_data, 'h0F0F);
    drain(40);
    check_beats(8'b0100_0010, "R7");
  endtask

  task automatic t_backpressure;
    logic [OUT_W-1:0] held;
    for (int c = 0; c < 8; c++) smp[c] = 18'(c * 333 + 100);
    build(mk_tag(1'b1, 1'b1, 1'b1, 8'b0000_0101), 7'h22, 16'h4444);
    send_bits(256);
    @(negedge clk);
    chk(pcm_valid && pcm_ch == 3'd0, "R9", "first beat offered", pcm_ch, 0);
    held = pcm_data;
    repeat (5) @(negedge clk);
    chk(pcm_valid && pcm_ch == 3'd0 && pcm_data == held, "R9", "beat held", pcm_data, held);
    @(posedge clk); #1; pcm_ready = 1'b1;
    @(posedge clk); #1; pcm_ready = 1'b0;
    @(negedge clk);
    chk(pcm_valid && pcm_ch == 3'd2, "R9", "one beat per handshake", pcm_ch, 2);
    drain(20);
    chk(got_n == 1 && got_ch[0] == 3'd2, "R9", "remaining beats", got_n, 1);
  endtask

  task automatic t_overwrite;
    logic [OUT_W-1:0] a0;
    for (int c = 0; c < 8; c++) smp[c] = 18'(c * 211 + 50);
    a0 = OUT_W'(exp_round(smp[0]));
    build(mk_tag(1'b1, 1'b1, 1'b1, 8'hFF), 7'h01, 16'h0001);
    send_bits(256);
    for (int c = 0; c < 8; c++) smp[c] = 18'h3F000 + 18'(c * 17);
    build(mk_tag(1'b1, 1'b1, 1'b1, 8'h80), 7'h02, 16'h0002);
    send_bits(256);
    drain(40);
    chk(got_n == 2, "R10", "beat count after overwrite", got_n, 2);
    chk(got_ch[0] == 3'd0 && got_d[0] == a0, "R10", "held beat of old frame", got_d[0], a0);
    chk(got_ch[1] == 3'd7 && got_d[1] == OUT_W'(exp_round(smp[7])), "R10", "new frame beat", got_d[1], exp_round(smp[7]));
  endtask

  task automatic t_abort;
    for (int c = 0; c < 8; c++) smp[c] = 18'(c + 1);
    build(mk_tag(1'b0, 1'b1, 1'b1, 8'hFF), 7'h7E, 16'hDEAD);
    send_bits(100);
    @(negedge clk);
    chk(link_ready == 1'b1 && stat_idx == 7'h02, "R11", "cut frame committed nothing", stat_idx, 2);
    chk(pcm_valid == 1'b0, "R11", "no beats from cut frame", pcm_valid, 0);
    build(mk_tag(1'b1, 1'b1, 1'b0, 8'h01), 7'h3C, 16'h0000);
    send_bits(256);
    @(negedge clk);
    chk(stat_idx == 7'h3C && stat_idx_vld, "R11", "restarted frame index", stat_idx, 'h3C);
    chk(stat_data_vld == 1'b0, "R6", "data valid off", stat_data_vld, 0);
    drain(20);
    check_beats(8'h01, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_not_ready();
    t_full();
    t_partial();
    t_backpressure();
    t_overwrite();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule